// File: doc/BRIEF.md
# Interprocessor Interrupt Command Register

This block is the command register pair through which one processor raises an interrupt on other processors. Software first writes the destination into the upper word. It then writes the lower word, which holds the vector, the delivery type, the addressing mode and an optional shorthand. The lower-word write is the trigger. The block works out which agents the message reaches and presents the message on a valid/ready output to the message fabric.

While the message has not yet been taken by the fabric, a status bit in the lower word reads as one, and software polls that bit until it clears. A lower-word write that arrives while a message is still in flight is dropped and raises a sticky error bit. The block has no other side effects.

The destination can be given in three ways. Physical mode names one agent by number. Logical mode gives a bitmask of agents. A shorthand code selects the sender only, every agent, or every agent except the sender, and the number of the sending agent is an input to the block.

Top module: `ipi_cmd_reg`

## Requirements
- R1: After reset the lower word (offset 0x300) and the upper word (offset 0x310) read as zero, msg_valid is low and no message is pending.
- R2: Register writes take effect at the clock edge that samples reg_we. Both words read back what was written, except that lower-word bits 12 and 13 are status bits that writes do not set.
- R3: An accepted lower-word write raises msg_valid in the following cycle. In that message, msg_vector equals bits 7:0 of the written word and msg_dtype equals bits 10:8.
- R4: With shorthand bits 19:18 = 00 and bit 11 = 0 (physical mode), the target mask is one-hot at agent number upper[31:24]. A number of NUM_AGENTS or more gives an empty mask.
- R5: With shorthand 00 and bit 11 = 1 (logical mode), the target mask is upper[31:24], taken as a bitmask over the agents.
- R6: Shorthand 01 targets self_id only, 10 targets every agent, and 11 targets every agent except self_id. Each shorthand ignores the upper word.
- R7: Lower-word bit 12 reads 1 from the cycle after a launch until the cycle after the valid/ready handshake, and msg_valid follows the same interval.
- R8: While msg_valid is high and msg_ready is low, the target mask, vector and delivery type hold steady.
- R9: A lower-word write while bit 12 reads 1 changes neither the stored word nor the message in flight. It sets lower-word bit 13, which stays set until reset.
- R10: A launch that resolves to an empty target mask sends no message and leaves bit 12 at 0.
- R11: Offsets other than 0x300 and 0x310 read as zero, and writes to them change neither word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| self_id | input | ID_W | Agent number of the sending processor |
| msg_valid | output | 1 | Message present on the output |
| msg_ready | input | 1 | Fabric accepts the message this cycle |
| msg_targets | output | NUM_AGENTS | Resolved target bitmask |
| msg_vector | output | 8 | Interrupt vector |
| msg_dtype | output | 3 | Delivery type |

## Verification
The bench holds msg_ready low across several cycles and writes the lower word a second time during that window. A design that let this write through would change the vector in flight or send a second message, and one that forgot the error would read bit 13 as zero. Every shorthand code is run with a non-zero self_id, which catches a swapped include/exclude or an off-by-one sender bit. Physical numbers past the last agent and an empty logical mask both check that nothing is launched, where a faulty design would raise msg_valid with no target or leave bit 12 stuck. A stray write to an unmapped offset, and a handshake taken with ready held high, cover address decode faults and a busy flag that clears one cycle late.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
    localparam int unsigned WORD_W      = 32;
    localparam int unsigned VEC_W       = 8;
    localparam int unsigned DTYPE_W     = 3;
    localparam int unsigned DEST_W      = 8;
    localparam int unsigned DEST_LSB    = 24;
    localparam int unsigned LOGICAL_BIT = 11;
    localparam int unsigned BUSY_BIT    = 12;
    localparam int unsigned ERR_BIT     = 13;
    localparam int unsigned SH_LSB      = 18;

    typedef enum logic [1:0] {
        SH_NONE   = 2'b00,
        SH_SELF   = 2'b01,
        SH_ALL    = 2'b10,
        SH_OTHERS = 2'b11
    } shorthand_e;

    typedef struct packed {
        shorthand_e               sh;
        logic                     logical;
        logic [DTYPE_W-1:0]       dtype;
        logic [VEC_W-1:0]         vector;
    } cmd_fields_t;

    function automatic cmd_fields_t split_low(input logic [WORD_W-1:0] w);
        cmd_fields_t f;
        f.sh      = shorthand_e'(w[SH_LSB+1:SH_LSB]);
        f.logical = w[LOGICAL_BIT];
        f.dtype   = w[VEC_W+DTYPE_W-1:VEC_W];
        f.vector  = w[VEC_W-1:0];
        return f;
    endfunction
endpackage

// File: rtl/ipi_target_resolve.sv
module ipi_target_resolve
    import ipi_pkg::*;
#(
    parameter int unsigned NUM_AGENTS = 8,
    parameter int unsigned ID_W       = 3
) (
    input  shorthand_e              sh,
    input  logic                    logical,
    input  logic [DEST_W-1:0]       dest,
    input  logic [ID_W-1:0]         self_id,
    output logic [NUM_AGENTS-1:0]   targets
);
    for (genvar g = 0; g < NUM_AGENTS; g++) begin : g_agent
        localparam logic [DEST_W-1:0] DEST_ID = DEST_W'(g);
        localparam logic [ID_W-1:0]   AGENT_ID = ID_W'(g);
        logic is_self;
        logic by_dest;
        assign is_self = (self_id == AGENT_ID);
        assign by_dest = logical ? dest[g] : (dest == DEST_ID);
        assign targets[g] = (sh == SH_NONE)  ? by_dest  :
                            (sh == SH_SELF)  ? is_self  :
                            (sh == SH_ALL)   ? 1'b1     :
                                               !is_self;
    end
endmodule

// File: rtl/ipi_read_mux.sv
module ipi_read_mux
    import ipi_pkg::*;
#(
    parameter int unsigned         ADDR_W   = 12,
    parameter logic [ADDR_W-1:0]   LOW_OFS  = 12'h300,
    parameter logic [ADDR_W-1:0]   HIGH_OFS = 12'h310
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [WORD_W-1:0]  low_word,
    input  logic [WORD_W-1:0]  high_word,
    input  logic               busy,
    input  logic               err,
    output logic [WORD_W-1:0]  rdata
);
    logic [WORD_W-1:0] low_view;

    always_comb begin
        low_view           = low_word;
        low_view[BUSY_BIT] = busy;
        low_view[ERR_BIT]  = err;
        if (addr == LOW_OFS)       rdata = low_view;
        else if (addr == HIGH_OFS) rdata = high_word;
        else                       rdata = '0;
    end
endmodule

// File: rtl/ipi_cmd_reg.sv
module ipi_cmd_reg
    import ipi_pkg::*;
#(
    parameter int unsigned         NUM_AGENTS = 8,
    parameter int unsigned         ADDR_W     = 12,
    parameter logic [ADDR_W-1:0]   LOW_OFS    = 12'h300,
    parameter logic [ADDR_W-1:0]   HIGH_OFS   = 12'h310,
    localparam int unsigned        ID_W       = (NUM_AGENTS > 1) ? $clog2(NUM_AGENTS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_we,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [WORD_W-1:0]       reg_wdata,
    output logic [WORD_W-1:0]       reg_rdata,
    input  logic [ID_W-1:0]         self_id,
    output logic                    msg_valid,
    input  logic                    msg_ready,
    output logic [NUM_AGENTS-1:0]   msg_targets,
    output logic [VEC_W-1:0]        msg_vector,
    output logic [DTYPE_W-1:0]      msg_dtype
);
    typedef struct packed {
        logic [WORD_W-1:0]     low;
        logic [WORD_W-1:0]     high;
        logic                  busy;
        logic                  err;
        logic [NUM_AGENTS-1:0] tgt;
    } state_t;

    state_t s_d, s_q;

    cmd_fields_t           wr_fields;
    logic [NUM_AGENTS-1:0] new_tgt;
    logic                  hit_low, hit_high;
    logic [NUM_AGENTS-1:0] self_oh;

    assign wr_fields = split_low(reg_wdata);
    assign hit_low   = reg_we && (reg_addr == LOW_OFS);
    assign hit_high  = reg_we && (reg_addr == HIGH_OFS);
    assign self_oh   = NUM_AGENTS'(1) << self_id;

    ipi_target_resolve #(
        .NUM_AGENTS (NUM_AGENTS),
        .ID_W       (ID_W)
    ) u_resolve (
        .sh      (wr_fields.sh),
        .logical (wr_fields.logical),
        .dest    (s_q.high[DEST_LSB+DEST_W-1:DEST_LSB]),
        .self_id (self_id),
        .targets (new_tgt)
    );

    ipi_read_mux #(
        .ADDR_W   (ADDR_W),
        .LOW_OFS  (LOW_OFS),
        .HIGH_OFS (HIGH_OFS)
    ) u_rmux (
        .addr      (reg_addr),
        .low_word  (s_q.low),
        .high_word (s_q.high),
        .busy      (s_q.busy),
        .err       (s_q.err),
        .rdata     (reg_rdata)
    );

    always_comb begin
        s_d = s_q;
        if (s_q.busy && msg_ready) begin
            s_d.busy = 1'b0;
        end
        if (hit_high) begin
            s_d.high = reg_wdata;
        end
        if (hit_low) begin
            if (s_q.busy) begin
                s_d.err = 1'b1;
            end else begin
                s_d.low           = reg_wdata;
                s_d.low[BUSY_BIT] = 1'b0;
                s_d.low[ERR_BIT]  = 1'b0;
                s_d.tgt           = new_tgt;
                s_d.busy          = |new_tgt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign msg_valid   = s_q.busy;
    assign msg_targets = s_q.tgt;
    assign msg_vector  = s_q.low[VEC_W-1:0];
    assign msg_dtype   = s_q.low[VEC_W+DTYPE_W-1:VEC_W];

    a_r8_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_targets)
                                    && $stable(msg_vector) && $stable(msg_dtype));

    a_r9_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        hit_low && msg_valid |=> $stable(s_q.low) && s_q.err);

    a_r9_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.err |=> s_q.err);

    a_r10_no_empty_message: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> msg_targets != '0);

    a_r7_clear_after_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_ready |=> !msg_valid);

    a_r6_others_skip_sender: assert property (@(posedge clk) disable iff (!rst_n)
        hit_low && !msg_valid && wr_fields.sh == SH_OTHERS
        |=> (msg_targets & $past(self_oh)) == '0);

    a_r3_broadcast_launches: assert property (@(posedge clk) disable iff (!rst_n)
        hit_low && !msg_valid && wr_fields.sh == SH_ALL |=> msg_valid);
endmodule

// File: tb/sim_ipi_cmd_reg.sv
module sim_ipi_cmd_reg;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_LOW  = 12'h300;
    localparam logic [11:0] A_HIGH = 12'h310;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  self_id = '0;
    logic        msg_valid;
    logic        msg_ready = 1'b0;
    logic [7:0]  msg_targets;
    logic [7:0]  msg_vector;
    logic [2:0]  msg_dtype;

    int nchecks = 0;
    int nerr = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipi_cmd_reg u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .self_id(self_id),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_targets(msg_targets),
        .msg_vector(msg_vector), .msg_dtype(msg_dtype)
    );

    // behavioural reference model
    logic [31:0] m_low = '0, m_high = '0;
    bit          m_busy = 0, m_err = 0;
    logic [7:0]  m_tgt = '0;

    function automatic logic [7:0] ref_targets(logic [31:0] w, logic [31:0] h, int self);
        logic [7:0] r;
        int id;
        case (w[19:18])
            2'b00: begin
                if (w[11]) r = h[31:24];
                else begin
                    id = int'(h[31:24]);
                    r = (id < 8) ? 8'(1 << id) : 8'h00;
                end
            end
            2'b01:   r = 8'(1 << self);
            2'b10:   r = 8'hFF;
            default: r = ~8'(1 << self);
        endcase
        return r;
    endfunction

    function automatic logic [31:0] ref_read(logic [11:0] a);
        if (a == A_LOW)  return (m_low & ~32'h3000) | (32'(m_busy) << 12) | (32'(m_err) << 13);
        if (a == A_HIGH) return m_high;
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_low = '0; m_high = '0; m_busy = 0; m_err = 0; m_tgt = '0;
        end else begin
            bit was_busy;
            logic [7:0] t;
            was_busy = m_busy;
            if (m_busy && msg_ready) m_busy = 0;
            if (reg_we && reg_addr == A_LOW) begin
                if (was_busy) m_err = 1;
                else begin
                    t = ref_targets(reg_wdata, m_high, int'(self_id));
                    m_low = reg_wdata & ~32'h3000;
                    m_tgt = t;
                    m_busy = (t != 0);
                end
            end
            if (reg_we && reg_addr == A_HIGH) m_high = reg_wdata;
        end
    end

    task automatic chk(input string rid, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", rid, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R7 valid", 32'(msg_valid), 32'(m_busy));
            if (m_busy) begin
                chk("R5 targets", 32'(msg_targets), 32'(m_tgt));
                chk("R3 vector", 32'(msg_vector), 32'(m_low[7:0]));
                chk("R3 dtype", 32'(msg_dtype), 32'(m_low[10:8]));
            end
            chk("R2 rdata", reg_rdata, ref_read(reg_addr));
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd_expect(input logic [11:0] a, input logic [31:0] exp, input string rid);
        reg_addr = a;
        @(negedge clk);
        chk(rid, reg_rdata, exp);
        @(posedge clk); #1;
    endtask

    task automatic expect_msg(input bit v, input logic [7:0] t, input logic [7:0] vec,
                              input logic [2:0] dt, input string rid);
        @(negedge clk);
        chk(rid, 32'(msg_valid), 32'(v));
        if (v) begin
            chk(rid, 32'(msg_targets), 32'(t));
            chk(rid, 32'(msg_vector), 32'(vec));
            chk(rid, 32'(msg_dtype), 32'(dt));
        end
        @(posedge clk); #1;
    endtask

    task automatic accept();
        msg_ready = 1'b1;
        @(posedge clk); #1;
        msg_ready = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        rd_expect(A_LOW, 32'h0, "R1");
        rd_expect(A_HIGH, 32'h0, "R1");
        expect_msg(0, 0, 0, 0, "R1");

        // R2 / R3 / R5: logical launch with fabric stalled
        wr(A_HIGH, 32'hA500_0000);
        rd_expect(A_HIGH, 32'hA500_0000, "R2");
        wr(A_LOW, 32'h0000_4B41);
        expect_msg(1, 8'hA5, 8'h41, 3'd3, "R3");
        rd_expect(A_LOW, 32'h0000_5B41, "R7");
        expect_msg(1, 8'hA5, 8'h41, 3'd3, "R8");
        expect_msg(1, 8'hA5, 8'h41, 3'd3, "R8");
        // R9: write while busy is dropped and flagged
        wr(A_LOW, 32'h0000_4B99);
        rd_expect(A_LOW, 32'h0000_7B41, "R9");
        expect_msg(1, 8'hA5, 8'h41, 3'd3, "R9");
        accept();
        rd_expect(A_LOW, 32'h0000_6B41, "R7");
        expect_msg(0, 0, 0, 0, "R7");

        // R4: physical destination
        wr(A_HIGH, 32'h0500_0000);
        wr(A_LOW, 32'h0000_4022);
        expect_msg(1, 8'h20, 8'h22, 3'd0, "R4");
        accept();
        wr(A_HIGH, 32'h0900_0000);
        wr(A_LOW, 32'h0000_4033);
        expect_msg(0, 0, 0, 0, "R10");
        rd_expect(A_LOW, 32'h0000_6033, "R10");

        // R6: shorthands with sender 3
        self_id = 3'd3;
        wr(A_LOW, 32'h0008_4050);
        expect_msg(1, 8'hFF, 8'h50, 3'd0, "R6");
        accept();
        wr(A_LOW, 32'h000C_4051);
        expect_msg(1, 8'hF7, 8'h51, 3'd0, "R6");
        accept();
        wr(A_LOW, 32'h0004_4052);
        expect_msg(1, 8'h08, 8'h52, 3'd0, "R6");
        accept();

        // R10: empty logical mask
        wr(A_HIGH, 32'h0000_0000);
        wr(A_LOW, 32'h0000_4860);
        expect_msg(0, 0, 0, 0, "R10");

        // R11: unmapped offset
        wr(12'h320, 32'hDEAD_BEEF);
        rd_expect(12'h320, 32'h0, "R11");
        rd_expect(A_HIGH, 32'h0, "R11");

        // R7: ready held high, one-cycle message
        msg_ready = 1'b1;
        wr(A_HIGH, 32'h3C00_0000);
        wr(A_LOW, 32'h0000_4A70);
        expect_msg(1, 8'h3C, 8'h70, 3'd2, "R5");
        expect_msg(0, 0, 0, 0, "R7");
        msg_ready = 1'b0;

        repeat (2) @(posedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end
endmodule